// File: doc/BRIEF.md
# Instruction Prefix Scanner

This block sits in front of an x86 opcode decoder. It takes the instruction byte stream one byte per cycle over a valid/ready handshake, recognises the legacy prefix bytes at the head of an instruction and files each one into a register for its group. A byte of the same group seen later replaces the earlier value. In 64-bit mode a REX byte is also captured, but only when it is the last prefix, directly ahead of the opcode.

Scanning ends at the first byte that is not a legacy prefix. That byte is left on the input for the opcode stage unless it is a REX byte. The block then pulses `done` with the collected prefix state and the number of bytes it consumed. If the scan reaches the architectural instruction length limit, the block pulses `error` instead.

A `start` pulse clears the collected state before each instruction. Opcode lookup, operand decoding and any later reuse of prefixes as mandatory opcode bytes belong to later stages.

Top module: `pfx_scanner`

## Requirements
- R1: Reset and a `start` pulse both clear every prefix output, `rex_valid` and `count` to zero. `start` begins a new scan, and no byte is accepted in the cycle `start` is high.
- R2: The segment override bytes load `seg_code` and set `seg_valid`. The codes are 0x26→0 (ES), 0x2E→1 (CS), 0x36→2 (SS), 0x3E→3 (DS), 0x64→4 (FS) and 0x65→5 (GS). The most recent segment byte sets the final code.
- R3: 0x66 sets `opsz_ovr`, 0x67 sets `adsz_ovr` and 0xF0 sets `lock`.
- R4: 0xF2 and 0xF3 share one register. `str_valid` is set, and `str_rep` is 1 for 0xF3 and 0 for 0xF2, following the last of the two seen.
- R5: The first offered byte that is neither a legacy prefix nor a captured REX byte ends the scan. It is not accepted (`in_ready` stays low for it), and one cycle later `done` rises with all prefix outputs and `count` valid.
- R6: When `mode` is 2 (64-bit) and the terminating byte has upper nibble 0x4, that byte is accepted, `rex_valid` is set and `rex` holds its low nibble (bit 3 W, bit 2 R, bit 1 X, bit 0 B). The scan then ends with `done`, so a legacy prefix after a REX byte is treated as the opcode.
- R7: When `mode` is 0 (16-bit), 1 (32-bit) or 3 (treated as 32-bit), a byte 0x40–0x4F ends the scan without being accepted, and `rex_valid` stays 0.
- R8: When `count` equals MAX_LEN−1 (14 by default) and a further byte is offered, the scan ends with a one-cycle `error` pulse. The byte is not accepted and `done` does not rise.
- R9: `count` goes up by exactly one for each accepted byte and does not change in any other cycle except on `start`.
- R10: `done` and `error` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clear state and begin a new scan |
| mode | input | 2 | Execution mode: 0 = 16-bit, 1 = 32-bit, 2 = 64-bit, 3 = treated as 32-bit |
| in_valid | input | 1 | Byte offered on `in_data` |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted this cycle |
| done | output | 1 | Scan finished normally (one-cycle pulse) |
| error | output | 1 | Length limit reached during the scan (one-cycle pulse) |
| seg_valid | output | 1 | A segment override was seen |
| seg_code | output | 3 | Segment selected by the last override |
| opsz_ovr | output | 1 | Operand-size override seen |
| adsz_ovr | output | 1 | Address-size override seen |
| lock | output | 1 | Lock prefix seen |
| str_valid | output | 1 | A repeat prefix was seen |
| str_rep | output | 1 | 1 = last repeat prefix was 0xF3, 0 = 0xF2 |
| rex_valid | output | 1 | REX byte captured |
| rex | output | 4 | Captured W, R, X, B bits |
| count | output | CNT_W | Bytes consumed in this scan |

## Verification
The bench builds the block with its default parameters: MAX_LEN of 15 and the 64-bit REX path enabled. With these values the length limit is reachable in a short run of fourteen repeated prefixes, and one more byte then produces the error. Running with the REX path enabled makes it possible to compare, byte for byte, the same 0x4X stream in 64-bit and non-64-bit modes. The directed streams also cover same-group overwrites for the segment and repeat groups, and a restart that follows a REX capture.

// File: rtl/pfxscan_pkg.sv
package pfxscan_pkg;

   typedef enum logic [1:0] {
      MODE_16  = 2'd0,
      MODE_32  = 2'd1,
      MODE_64  = 2'd2,
      MODE_RSV = 2'd3
   } cpu_mode_e;

   typedef enum logic [2:0] {
      SEG_ES = 3'd0,
      SEG_CS = 3'd1,
      SEG_SS = 3'd2,
      SEG_DS = 3'd3,
      SEG_FS = 3'd4,
      SEG_GS = 3'd5
   } seg_e;

   typedef enum logic [2:0] {
      K_NONE = 3'd0,
      K_SEG  = 3'd1,
      K_OPSZ = 3'd2,
      K_ADSZ = 3'd3,
      K_LOCK = 3'd4,
      K_STR  = 3'd5,
      K_REX  = 3'd6
   } byte_kind_e;

   typedef struct packed {
      byte_kind_e kind;
      seg_e       seg;
      logic       rep;
   } byte_class_t;

endpackage

// File: rtl/pfxscan_classify.sv
module pfxscan_classify
   import pfxscan_pkg::*;
#(
   parameter bit LONG_MODE_EN = 1'b1
) (
   input  logic [7:0]  byte_i,
   input  logic        is64_i,
   output byte_class_t cls_o
);

   logic rex_hit;

   generate
      if (LONG_MODE_EN) begin : g_rex
         assign rex_hit = is64_i && (byte_i[7:4] == 4'h4);
      end else begin : g_no_rex
         logic unused_is64;
         assign unused_is64 = is64_i;
         assign rex_hit     = 1'b0;
      end
   endgenerate

   always_comb begin
      cls_o.kind = K_NONE;
      cls_o.seg  = SEG_ES;
      cls_o.rep  = 1'b0;
      unique case (byte_i)
         8'h26: begin cls_o.kind = K_SEG; cls_o.seg = SEG_ES; end
         8'h2E: begin cls_o.kind = K_SEG; cls_o.seg = SEG_CS; end
         8'h36: begin cls_o.kind = K_SEG; cls_o.seg = SEG_SS; end
         8'h3E: begin cls_o.kind = K_SEG; cls_o.seg = SEG_DS; end
         8'h64: begin cls_o.kind = K_SEG; cls_o.seg = SEG_FS; end
         8'h65: begin cls_o.kind = K_SEG; cls_o.seg = SEG_GS; end
         8'h66: cls_o.kind = K_OPSZ;
         8'h67: cls_o.kind = K_ADSZ;
         8'hF0: cls_o.kind = K_LOCK;
         8'hF2: begin cls_o.kind = K_STR; cls_o.rep = 1'b0; end
         8'hF3: begin cls_o.kind = K_STR; cls_o.rep = 1'b1; end
         default: begin
            if (rex_hit) cls_o.kind = K_REX;
         end
      endcase
   end

endmodule

// File: rtl/pfxscan_ctrl.sv
module pfxscan_ctrl
   import pfxscan_pkg::*;
#(
   parameter int MAX_LEN = 15,
   parameter int CNT_W   = $clog2(MAX_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             valid_i,
   input  byte_kind_e       kind_i,
   output logic             ready_o,
   output logic [CNT_W-1:0] count_o,
   output logic             done_o,
   output logic             error_o
);

   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MAX_LEN - 1);

   logic scanning;
   logic offered;
   logic at_limit;
   logic finish_ok;
   logic finish_err;

   assign offered    = scanning && !start_i && valid_i;
   assign at_limit   = (count_o == LAST_CNT);
   assign ready_o    = offered && !at_limit && (kind_i != K_NONE);
   assign finish_ok  = offered && !at_limit &&
                       ((kind_i == K_NONE) || (kind_i == K_REX));
   assign finish_err = offered && at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scanning <= 1'b0;
         count_o  <= '0;
         done_o   <= 1'b0;
         error_o  <= 1'b0;
      end else begin
         done_o  <= finish_ok;
         error_o <= finish_err;
         if (start_i) begin
            scanning <= 1'b1;
            count_o  <= '0;
         end else begin
            if (ready_o) count_o <= count_o + 1'b1;
            if (finish_ok || finish_err) scanning <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pfxscan_regs.sv
module pfxscan_regs
   import pfxscan_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear_i,
   input  logic        take_i,
   input  byte_class_t cls_i,
   input  logic [3:0]  low_i,
   output logic        seg_valid_o,
   output logic [2:0]  seg_code_o,
   output logic        opsz_o,
   output logic        adsz_o,
   output logic        lock_o,
   output logic        str_valid_o,
   output logic        str_rep_o,
   output logic        rex_valid_o,
   output logic [3:0]  rex_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_valid_o <= 1'b0;
         seg_code_o  <= '0;
         opsz_o      <= 1'b0;
         adsz_o      <= 1'b0;
         lock_o      <= 1'b0;
         str_valid_o <= 1'b0;
         str_rep_o   <= 1'b0;
         rex_valid_o <= 1'b0;
         rex_o       <= '0;
      end else if (clear_i) begin
         seg_valid_o <= 1'b0;
         seg_code_o  <= '0;
         opsz_o      <= 1'b0;
         adsz_o      <= 1'b0;
         lock_o      <= 1'b0;
         str_valid_o <= 1'b0;
         str_rep_o   <= 1'b0;
         rex_valid_o <= 1'b0;
         rex_o       <= '0;
      end else if (take_i) begin
         case (cls_i.kind)
            K_SEG: begin
               seg_valid_o <= 1'b1;
               seg_code_o  <= cls_i.seg;
            end
            K_OPSZ: opsz_o <= 1'b1;
            K_ADSZ: adsz_o <= 1'b1;
            K_LOCK: lock_o <= 1'b1;
            K_STR: begin
               str_valid_o <= 1'b1;
               str_rep_o   <= cls_i.rep;
            end
            K_REX: begin
               rex_valid_o <= 1'b1;
               rex_o       <= low_i;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pfx_scanner.sv
module pfx_scanner
   import pfxscan_pkg::*;
#(
   parameter int  MAX_LEN      = 15,
   parameter bit  LONG_MODE_EN = 1'b1,
   localparam int CNT_W        = $clog2(MAX_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       mode,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   output logic             in_ready,
   output logic             done,
   output logic             error,
   output logic             seg_valid,
   output logic [2:0]       seg_code,
   output logic             opsz_ovr,
   output logic             adsz_ovr,
   output logic             lock,
   output logic             str_valid,
   output logic             str_rep,
   output logic             rex_valid,
   output logic [3:0]       rex,
   output logic [CNT_W-1:0] count
);

   generate
      if (MAX_LEN < 2 || MAX_LEN > 255) begin : g_bad_len
         $error("pfx_scanner: MAX_LEN must lie in 2..255");
      end
   endgenerate

   byte_class_t cls;
   logic        is64;

   assign is64 = (mode == MODE_64);

   pfxscan_classify #(
      .LONG_MODE_EN (LONG_MODE_EN)
   ) i_classify (
      .byte_i (in_data),
      .is64_i (is64),
      .cls_o  (cls)
   );

   pfxscan_ctrl #(
      .MAX_LEN (MAX_LEN),
      .CNT_W   (CNT_W)
   ) i_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .valid_i (in_valid),
      .kind_i  (cls.kind),
      .ready_o (in_ready),
      .count_o (count),
      .done_o  (done),
      .error_o (error)
   );

   pfxscan_regs i_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (start),
      .take_i      (in_ready),
      .cls_i       (cls),
      .low_i       (in_data[3:0]),
      .seg_valid_o (seg_valid),
      .seg_code_o  (seg_code),
      .opsz_o      (opsz_ovr),
      .adsz_o      (adsz_ovr),
      .lock_o      (lock),
      .str_valid_o (str_valid),
      .str_rep_o   (str_rep),
      .rex_valid_o (rex_valid),
      .rex_o       (rex)
   );

endmodule

// File: rtl/pfx_scanner_checker.sv
module pfx_scanner_checker #(
   parameter int MAX_LEN = 15,
   parameter int CNT_W   = $clog2(MAX_LEN)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [1:0]       mode,
   input logic             in_valid,
   input logic [7:0]       in_data,
   input logic             in_ready,
   input logic             done,
   input logic             error,
   input logic             seg_valid,
   input logic             opsz_ovr,
   input logic             adsz_ovr,
   input logic             lock,
   input logic             str_valid,
   input logic             rex_valid,
   input logic [CNT_W-1:0] count
);

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (count == '0) && !seg_valid && !opsz_ovr && !adsz_ovr &&
                !lock && !str_valid && !rex_valid)
      else $error("start did not clear state"); // R1

   AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> in_valid && !start)
      else $error("byte accepted without offer or during start"); // R9

   AST_NO_REX_OUTSIDE_64: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && (mode != 2'd2)) |-> (in_data[7:4] != 4'h4))
      else $error("0x4X byte consumed outside 64-bit mode"); // R7

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count) <= MAX_LEN - 1)
      else $error("count exceeded the length limit"); // R8

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> count == $past(count) + 1'b1)
      else $error("count did not step on accept"); // R9

   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && !start) |=> $stable(count))
      else $error("count moved without accept"); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle"); // R10

   AST_ERROR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> !error)
      else $error("error longer than one cycle"); // R10

   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error))
      else $error("done and error together"); // R10

endmodule

bind pfx_scanner pfx_scanner_checker #(
   .MAX_LEN (MAX_LEN),
   .CNT_W   (CNT_W)
) i_pfx_scanner_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .mode      (mode),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .in_ready  (in_ready),
   .done      (done),
   .error     (error),
   .seg_valid (seg_valid),
   .opsz_ovr  (opsz_ovr),
   .adsz_ovr  (adsz_ovr),
   .lock      (lock),
   .str_valid (str_valid),
   .rex_valid (rex_valid),
   .count     (count)
);

// File: tb/test_pfx_scanner.sv
`timescale 1ns/1ps
module test_pfx_scanner;

   localparam int MAX_LEN = 15;
   localparam int CNT_W   = $clog2(MAX_LEN);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [1:0]       mode = 2'd1;
   logic             in_valid = 1'b0;
   logic [7:0]       in_data = 8'h00;
   logic             in_ready;
   logic             done;
   logic             error;
   logic             seg_valid;
   logic [2:0]       seg_code;
   logic             opsz_ovr;
   logic             adsz_ovr;
   logic             lock;
   logic             str_valid;
   logic             str_rep;
   logic             rex_valid;
   logic [3:0]       rex;
   logic [CNT_W-1:0] count;

   int checks = 0;
   int failures = 0;

   logic [7:0] stim [0:31];
   int  consumed;
   bit  saw_done;
   bit  saw_err;
   bit  last_ready;

   always #2 clk = ~clk;

   pfx_scanner #(
      .MAX_LEN      (MAX_LEN),
      .LONG_MODE_EN (1'b1)
   ) i_pfx_scanner (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mode      (mode),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .done      (done),
      .error     (error),
      .seg_valid (seg_valid),
      .seg_code  (seg_code),
      .opsz_ovr  (opsz_ovr),
      .adsz_ovr  (adsz_ovr),
      .lock      (lock),
      .str_valid (str_valid),
      .str_rep   (str_rep),
      .rex_valid (rex_valid),
      .rex       (rex),
      .count     (count)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input string what, input int act, input int exp);
      chk(act == exp, req, what, act, exp);
   endtask

   task automatic chk_state(input string req, input int sv, input int sc, input int os,
                            input int as, input int lk, input int stv, input int rp,
                            input int rv, input int rx, input int cn);
      chk_eq(req, "seg_valid", int'(seg_valid), sv);
      if (sv != 0) chk_eq(req, "seg_code", int'(seg_code), sc);
      chk_eq(req, "opsz_ovr", int'(opsz_ovr), os);
      chk_eq(req, "adsz_ovr", int'(adsz_ovr), as);
      chk_eq(req, "lock", int'(lock), lk);
      chk_eq(req, "str_valid", int'(str_valid), stv);
      if (stv != 0) chk_eq(req, "str_rep", int'(str_rep), rp);
      chk_eq(req, "rex_valid", int'(rex_valid), rv);
      if (rv != 0) chk_eq(req, "rex", int'(rex), rx);
      chk_eq(req, "count", int'(count), cn);
   endtask

   // Pulse start, then feed stim[0..n-1]; stops at the negedge where done or error shows.
   task automatic run_scan(input logic [1:0] m, input int n);
      mode = m;
      @(negedge clk);
      start = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);
      start = 1'b0;
      consumed = 0;
      saw_done = 1'b0;
      saw_err = 1'b0;
      last_ready = 1'b0;
      for (int cyc = 0; cyc < 48; cyc++) begin
         if (done)  begin saw_done = 1'b1; break; end
         if (error) begin saw_err  = 1'b1; break; end
         in_valid = (consumed < n);
         in_data  = (consumed < n) ? stim[consumed] : 8'h00;
         #1;
         last_ready = in_ready;
         if (in_ready) consumed++;
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk_eq("R1", "reset done", int'(done), 0);
      chk_eq("R1", "reset error", int'(error), 0);
      chk_eq("R1", "reset in_ready", int'(in_ready), 0);
      chk_state("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_basic32;
      stim[0] = 8'h2E; stim[1] = 8'h66; stim[2] = 8'hF3; stim[3] = 8'h90;
      run_scan(2'd1, 4);
      chk_eq("R5", "done seen", int'(saw_done), 1);
      chk_eq("R5", "opcode not accepted", int'(last_ready), 0);
      chk_eq("R5", "bytes accepted", consumed, 3);
      chk_state("R2", 1, 1, 1, 0, 0, 1, 1, 0, 0, 3);
      @(negedge clk);
      chk_eq("R10", "done single cycle", int'(done), 0);
   endtask

   task automatic t_overwrite;
      stim[0] = 8'h26; stim[1] = 8'h64; stim[2] = 8'hF2; stim[3] = 8'hF3;
      stim[4] = 8'hF2; stim[5] = 8'h0F;
      run_scan(2'd0, 6);
      chk_eq("R5", "done seen", int'(saw_done), 1);
      chk_state("R4", 1, 4, 0, 0, 0, 1, 0, 0, 0, 5);
      stim[0] = 8'h3E; stim[1] = 8'h65; stim[2] = 8'h36; stim[3] = 8'hF3; stim[4] = 8'h8B;
      run_scan(2'd1, 5);
      chk_state("R2", 1, 2, 0, 0, 0, 1, 1, 0, 0, 4);
      stim[0] = 8'h36; stim[1] = 8'h3E; stim[2] = 8'h01;
      run_scan(2'd1, 3);
      chk_state("R2", 1, 3, 0, 0, 0, 0, 0, 0, 0, 2);
      stim[0] = 8'h26; stim[1] = 8'h65; stim[2] = 8'h01;
      run_scan(2'd1, 3);
      chk_state("R2", 1, 5, 0, 0, 0, 0, 0, 0, 0, 2);
   endtask

   task automatic t_rex64;
      stim[0] = 8'h67; stim[1] = 8'hF0; stim[2] = 8'h4C; stim[3] = 8'h0F;
      run_scan(2'd2, 4);
      chk_eq("R6", "done seen", int'(saw_done), 1);
      chk_eq("R6", "rex accepted", consumed, 3);
      chk_state("R6", 0, 0, 0, 1, 1, 0, 0, 1, 12, 3);
      chk_eq("R6", "W bit", int'(rex[3]), 1);
      chk_eq("R6", "B bit", int'(rex[0]), 0);
      chk_eq("R3", "adsz flag", int'(adsz_ovr), 1);
      @(negedge clk);
      chk_eq("R10", "done single cycle", int'(done), 0);
      // REX followed by a legacy prefix: the prefix is the opcode
      stim[0] = 8'h48; stim[1] = 8'h66; stim[2] = 8'h90;
      run_scan(2'd2, 3);
      chk_eq("R6", "stop after rex", consumed, 1);
      chk_state("R6", 0, 0, 0, 0, 0, 0, 0, 1, 8, 1);
   endtask

   task automatic t_rex_other_modes;
      stim[0] = 8'h66; stim[1] = 8'h48; stim[2] = 8'h90;
      run_scan(2'd1, 3);
      chk_eq("R7", "done seen", int'(saw_done), 1);
      chk_eq("R7", "4X not accepted", int'(last_ready), 0);
      chk_state("R7", 0, 0, 1, 0, 0, 0, 0, 0, 0, 1);
      stim[0] = 8'h41;
      run_scan(2'd0, 1);
      chk_state("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      stim[0] = 8'h4F;
      run_scan(2'd3, 1);
      chk_state("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_limit;
      for (int i = 0; i < MAX_LEN; i++) stim[i] = 8'h66;
      run_scan(2'd1, MAX_LEN);
      chk_eq("R8", "error seen", int'(saw_err), 1);
      chk_eq("R8", "done absent", int'(saw_done), 0);
      chk_eq("R8", "done with error", int'(done), 0);
      chk_eq("R8", "last byte refused", int'(last_ready), 0);
      chk_eq("R8", "count at limit", int'(count), MAX_LEN - 1);
      @(negedge clk);
      chk_eq("R10", "error single cycle", int'(error), 0);
      for (int i = 0; i < MAX_LEN - 2; i++) stim[i] = 8'hF0;
      stim[MAX_LEN - 2] = 8'h90;
      run_scan(2'd1, MAX_LEN - 1);
      chk_eq("R8", "below limit no error", int'(saw_err), 0);
      chk_eq("R9", "below limit done", int'(saw_done), 1);
      chk_eq("R9", "below limit count", int'(count), MAX_LEN - 2);
      chk_eq("R3", "lock flag", int'(lock), 1);
   endtask

   task automatic t_restart;
      stim[0] = 8'h2E; stim[1] = 8'h67; stim[2] = 8'h4F; stim[3] = 8'h90;
      run_scan(2'd2, 4);
      chk_state("R6", 1, 1, 0, 1, 0, 0, 0, 1, 15, 3);
      mode = 2'd0;
      @(negedge clk);
      start = 1'b1;
      in_valid = 1'b1;
      in_data = 8'h66;
      #1;
      chk_eq("R1", "no accept during start", int'(in_ready), 0);
      @(negedge clk);
      start = 1'b0;
      in_valid = 1'b0;
      chk_state("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      stim[0] = 8'h90;
      run_scan(2'd0, 1);
      chk_eq("R5", "immediate opcode done", int'(saw_done), 1);
      chk_state("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #400000;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_basic32();
      t_overwrite();
      t_rex64();
      t_rex_other_modes();
      t_limit();
      t_restart();
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule